// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits on the upstream side of a PCI-to-PCI bridge and decides whether a request address should be claimed and forwarded downstream. It keeps no configuration storage of its own. The raw base, limit and upper-extension register fields come in as ports. From these it rebuilds three forwarding windows: one for I/O, one for non-prefetchable memory and one for prefetchable memory. Each window is turned on or off by the matching command enable.

A request gives a 64-bit address and a space flag. One cycle after the request strobe, the block reports whether the request hits and which window claimed it. The legacy display ranges are also forwarded when the display-forwarding control bit is set, whatever the windows hold. Memory requests are compared only with the two memory windows, and I/O requests only with the I/O window.

Top module: `bridge_window_decoder`

## Requirements
- R1: `hit_vld_o` is high exactly in the cycle after a cycle with `req_vld_i` high, and low otherwise. `hit_o`/`win_o` take the result of that request at the same edge and hold it until the next request.
- R2: I/O window base = {`io_base_hi_i` if `io_base_i[3:0]`==1 else 16'h0, `io_base_i[7:4]`, 12'h000}. The limit is built the same way from `io_limit_i` and `io_limit_hi_i`, with its low 12 bits all ones.
- R3: Non-prefetchable window base = {`mem_base_i[15:4]`, 20'h00000}. The limit = {`mem_limit_i[15:4]`, 20'hFFFFF}. Bits 63:32 of both are zero.
- R4: Prefetchable window base = {`pf_base_hi_i` if `pf_base_i[3:0]`==1 else 32'h0, `pf_base_i[15:4]`, 20'h00000}. The limit is built the same way from `pf_limit_i` and `pf_limit_hi_i`, with its low 20 bits all ones.
- R5: The I/O window can hit only while `cmd_io_en_i` is high. Both memory windows can hit only while `cmd_mem_en_i` is high.
- R6: A window hits when base <= address <= limit, compared unsigned over 64 bits. A window whose limit is below its base never hits.
- R7: While `vga_en_i` is high, memory 0xA0000–0xBFFFF and I/O 0x3B0–0x3BB and 0x3C0–0x3DF hit with code 0. This is independent of the windows and the command enables. While `vga_en_i` is low these ranges hit only through a window.
- R8: An I/O request (`req_is_io_i`=1) is matched only against the I/O window and the legacy I/O ranges. A memory request is matched only against the two memory windows and the legacy memory range.
- R9: Window codes are 1 = I/O, 2 = non-prefetchable, 3 = prefetchable, 0 = legacy display range or miss. A miss gives `hit_o`=0 and `win_o`=0. The priority is non-prefetchable over prefetchable over the legacy range, and the I/O window over the legacy range.
- R10: While `rst_ni` is low, `hit_vld_o`, `hit_o` and `win_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_base_i | input | 8 | I/O base field: [7:4] address bits 15:12, [3:0] type |
| io_limit_i | input | 8 | I/O limit field: [7:4] address bits 15:12, [3:0] type |
| io_base_hi_i | input | 16 | I/O base address bits 31:16 |
| io_limit_hi_i | input | 16 | I/O limit address bits 31:16 |
| mem_base_i | input | 16 | Non-prefetchable base field, [15:4] used |
| mem_limit_i | input | 16 | Non-prefetchable limit field, [15:4] used |
| pf_base_i | input | 16 | Prefetchable base field: [15:4] address bits 31:20, [3:0] type |
| pf_limit_i | input | 16 | Prefetchable limit field: [15:4] address bits 31:20, [3:0] type |
| pf_base_hi_i | input | 32 | Prefetchable base address bits 63:32 |
| pf_limit_hi_i | input | 32 | Prefetchable limit address bits 63:32 |
| cmd_io_en_i | input | 1 | I/O space enable |
| cmd_mem_en_i | input | 1 | Memory space enable |
| vga_en_i | input | 1 | Legacy display range forwarding enable |
| req_vld_i | input | 1 | Request strobe |
| req_is_io_i | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr_i | input | 64 | Request address |
| hit_vld_o | output | 1 | Result valid, one cycle after the strobe |
| hit_o | output | 1 | Request is forwarded |
| win_o | output | 2 | Code of the claiming window |

## Verification
On every cycle the assertions check four things: the one-cycle strobe-to-result latency, that a disabled space can never be claimed by its window, that memory codes never answer an I/O request, and that a miss always carries code 0. The exact bound arithmetic needs the bench's scenarios to show it: the low-bit fill of limits, the type code selecting an upper register, the empty-window rule and the priority between overlapping windows. The same holds for the legacy range edges and the display-enable gating.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W  = 64;
  localparam int NUM_WIN = 3;
  localparam int IO_FILL_W  = 12;
  localparam int MEM_FILL_W = 20;

  typedef enum logic [1:0] {
    WIN_VGA  = 2'd0,
    WIN_IO   = 2'd1,
    WIN_MEM  = 2'd2,
    WIN_PREF = 2'd3
  } win_id_e;

  localparam int W_IO   = 0;
  localparam int W_MEM  = 1;
  localparam int W_PREF = 2;

  localparam logic [ADDR_W-1:0] VGA_MEM_LO  = 64'h000A_0000;
  localparam logic [ADDR_W-1:0] VGA_MEM_HI  = 64'h000B_FFFF;
  localparam logic [ADDR_W-1:0] VGA_IOA_LO  = 64'h3B0;
  localparam logic [ADDR_W-1:0] VGA_IOA_HI  = 64'h3BB;
  localparam logic [ADDR_W-1:0] VGA_IOB_LO  = 64'h3C0;
  localparam logic [ADDR_W-1:0] VGA_IOB_HI  = 64'h3DF;

  localparam logic [3:0] TYPE_WIDE = 4'h1;
endpackage

// File: rtl/bwd_bounds.sv
module bwd_bounds
  import bwd_pkg::*;
(
  input  logic [7:0]        io_base_i,
  input  logic [7:0]        io_limit_i,
  input  logic [15:0]       io_base_hi_i,
  input  logic [15:0]       io_limit_hi_i,
  input  logic [15:0]       mem_base_i,
  input  logic [15:0]       mem_limit_i,
  input  logic [15:0]       pf_base_i,
  input  logic [15:0]       pf_limit_i,
  input  logic [31:0]       pf_base_hi_i,
  input  logic [31:0]       pf_limit_hi_i,
  output logic [ADDR_W-1:0] base_o  [NUM_WIN],
  output logic [ADDR_W-1:0] limit_o [NUM_WIN]
);
  localparam logic [IO_FILL_W-1:0]  IO_ONES  = '1;
  localparam logic [MEM_FILL_W-1:0] MEM_ONES = '1;

  logic [15:0] io_bhi, io_lhi;
  logic [31:0] pf_bhi, pf_lhi;
  logic        unused_type;

  // upper extension only counts when the type code says wide
  assign io_bhi = (io_base_i[3:0]  == TYPE_WIDE) ? io_base_hi_i  : '0;
  assign io_lhi = (io_limit_i[3:0] == TYPE_WIDE) ? io_limit_hi_i : '0;
  assign pf_bhi = (pf_base_i[3:0]  == TYPE_WIDE) ? pf_base_hi_i  : '0;
  assign pf_lhi = (pf_limit_i[3:0] == TYPE_WIDE) ? pf_limit_hi_i : '0;
  assign unused_type = ^{mem_base_i[3:0], mem_limit_i[3:0]};

  assign base_o[W_IO]    = {32'h0, io_bhi, io_base_i[7:4], {IO_FILL_W{1'b0}}};
  assign limit_o[W_IO]   = {32'h0, io_lhi, io_limit_i[7:4], IO_ONES};
  assign base_o[W_MEM]   = {32'h0, mem_base_i[15:4], {MEM_FILL_W{1'b0}}};
  assign limit_o[W_MEM]  = {32'h0, mem_limit_i[15:4], MEM_ONES};
  assign base_o[W_PREF]  = {pf_bhi, pf_base_i[15:4], {MEM_FILL_W{1'b0}}};
  assign limit_o[W_PREF] = {pf_lhi, pf_limit_i[15:4], MEM_ONES};
endmodule

// File: rtl/bwd_win_cmp.sv
module bwd_win_cmp
  import bwd_pkg::*;
(
  input  logic              en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  // limit < base leaves no address satisfying both bounds
  assign hit_o = en_i && (addr_i >= base_i) && (addr_i <= limit_i);
endmodule

// File: rtl/bwd_vga_match.sv
module bwd_vga_match
  import bwd_pkg::*;
(
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              io_hit_o,
  output logic              mem_hit_o
);
  logic in_a, in_b;
  assign in_a      = (addr_i >= VGA_IOA_LO) && (addr_i <= VGA_IOA_HI);
  assign in_b      = (addr_i >= VGA_IOB_LO) && (addr_i <= VGA_IOB_HI);
  assign io_hit_o  = en_i && (in_a || in_b);
  assign mem_hit_o = en_i && (addr_i >= VGA_MEM_LO) && (addr_i <= VGA_MEM_HI);
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        io_base_i,
  input  logic [7:0]        io_limit_i,
  input  logic [15:0]       io_base_hi_i,
  input  logic [15:0]       io_limit_hi_i,
  input  logic [15:0]       mem_base_i,
  input  logic [15:0]       mem_limit_i,
  input  logic [15:0]       pf_base_i,
  input  logic [15:0]       pf_limit_i,
  input  logic [31:0]       pf_base_hi_i,
  input  logic [31:0]       pf_limit_hi_i,
  input  logic              cmd_io_en_i,
  input  logic              cmd_mem_en_i,
  input  logic              vga_en_i,
  input  logic              req_vld_i,
  input  logic              req_is_io_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              hit_vld_o,
  output logic              hit_o,
  output logic [1:0]        win_o
);
  logic [ADDR_W-1:0] win_base [NUM_WIN];
  logic [ADDR_W-1:0] win_lim  [NUM_WIN];
  logic [NUM_WIN-1:0] win_en, cmp_hit;
  logic vga_io_hit, vga_mem_hit;
  logic sel_hit;
  win_id_e sel_win;

  bwd_bounds u_bounds (
    .io_base_i    (io_base_i),
    .io_limit_i   (io_limit_i),
    .io_base_hi_i (io_base_hi_i),
    .io_limit_hi_i(io_limit_hi_i),
    .mem_base_i   (mem_base_i),
    .mem_limit_i  (mem_limit_i),
    .pf_base_i    (pf_base_i),
    .pf_limit_i   (pf_limit_i),
    .pf_base_hi_i (pf_base_hi_i),
    .pf_limit_hi_i(pf_limit_hi_i),
    .base_o       (win_base),
    .limit_o      (win_lim)
  );

  assign win_en[W_IO]   = cmd_io_en_i;
  assign win_en[W_MEM]  = cmd_mem_en_i;
  assign win_en[W_PREF] = cmd_mem_en_i;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    bwd_win_cmp u_cmp (
      .en_i   (win_en[w]),
      .base_i (win_base[w]),
      .limit_i(win_lim[w]),
      .addr_i (req_addr_i),
      .hit_o  (cmp_hit[w])
    );
  end

  bwd_vga_match u_vga (
    .en_i     (vga_en_i),
    .addr_i   (req_addr_i),
    .io_hit_o (vga_io_hit),
    .mem_hit_o(vga_mem_hit)
  );

  always_comb begin
    sel_hit = 1'b0;
    sel_win = WIN_VGA;
    if (req_is_io_i) begin
      if (cmp_hit[W_IO]) begin
        sel_hit = 1'b1; sel_win = WIN_IO;
      end else if (vga_io_hit) begin
        sel_hit = 1'b1; sel_win = WIN_VGA;
      end
    end else begin
      if (cmp_hit[W_MEM]) begin
        sel_hit = 1'b1; sel_win = WIN_MEM;
      end else if (cmp_hit[W_PREF]) begin
        sel_hit = 1'b1; sel_win = WIN_PREF;
      end else if (vga_mem_hit) begin
        sel_hit = 1'b1; sel_win = WIN_VGA;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_vld_o <= 1'b0;
      hit_o     <= 1'b0;
      win_o     <= WIN_VGA;
    end else begin
      hit_vld_o <= req_vld_i;
      if (req_vld_i) begin
        hit_o <= sel_hit;
        win_o <= sel_win;
      end
    end
  end

  a_r1_vld_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_vld_i |=> hit_vld_o);
  a_r1_vld_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_vld_i |=> !hit_vld_o);
  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_vld_i |=> ($stable(hit_o) && $stable(win_o)));
  a_r5_io_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && req_is_io_i && !cmd_io_en_i) |=> !(hit_o && win_o == WIN_IO));
  a_r5_mem_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && !req_is_io_i && !cmd_mem_en_i)
      |=> !(hit_o && (win_o == WIN_MEM || win_o == WIN_PREF)));
  a_r7_vga_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && req_is_io_i && !cmd_io_en_i && !vga_en_i) |=> !hit_o);
  a_r8_io_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && req_is_io_i) |=> (win_o != WIN_MEM && win_o != WIN_PREF));
  a_r9_miss_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> win_o == WIN_VGA);
endmodule

// File: tb/bridge_window_decoder_tb_top.sv
module bridge_window_decoder_tb_top;
  import bwd_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  io_base, io_limit;
  logic [15:0] io_base_hi, io_limit_hi, mem_base, mem_limit, pf_base, pf_limit;
  logic [31:0] pf_base_hi, pf_limit_hi;
  logic cmd_io, cmd_mem, vga_en, req_vld, req_io;
  logic [63:0] req_addr;
  logic hit_vld, hit;
  logic [1:0] win;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bridge_window_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .io_base_i(io_base), .io_limit_i(io_limit),
    .io_base_hi_i(io_base_hi), .io_limit_hi_i(io_limit_hi),
    .mem_base_i(mem_base), .mem_limit_i(mem_limit),
    .pf_base_i(pf_base), .pf_limit_i(pf_limit),
    .pf_base_hi_i(pf_base_hi), .pf_limit_hi_i(pf_limit_hi),
    .cmd_io_en_i(cmd_io), .cmd_mem_en_i(cmd_mem), .vga_en_i(vga_en),
    .req_vld_i(req_vld), .req_is_io_i(req_io), .req_addr_i(req_addr),
    .hit_vld_o(hit_vld), .hit_o(hit), .win_o(win)
  );

  // {addr, is_io, exp_hit, exp_win}
  localparam int NV = 26;
  localparam logic [67:0] VEC [NV] = '{
    {64'h0000_0000_0001_2000, 1'b1, 1'b1, 2'd1},
    {64'h0000_0000_0001_3FFF, 1'b1, 1'b1, 2'd1},
    {64'h0000_0000_0001_1FFF, 1'b1, 1'b0, 2'd0},
    {64'h0000_0000_0001_4000, 1'b1, 1'b0, 2'd0},
    {64'h0000_0000_0000_03B0, 1'b1, 1'b1, 2'd0},
    {64'h0000_0000_0000_03BB, 1'b1, 1'b1, 2'd0},
    {64'h0000_0000_0000_03BC, 1'b1, 1'b0, 2'd0},
    {64'h0000_0000_0000_03C0, 1'b1, 1'b1, 2'd0},
    {64'h0000_0000_0000_03DF, 1'b1, 1'b1, 2'd0},
    {64'h0000_0000_0000_03E0, 1'b1, 1'b0, 2'd0},
    {64'h0000_0000_C010_0000, 1'b0, 1'b1, 2'd2},
    {64'h0000_0000_C03F_FFFF, 1'b0, 1'b1, 2'd2},
    {64'h0000_0000_C040_0000, 1'b0, 1'b0, 2'd0},
    {64'h0000_0000_C00F_FFFF, 1'b0, 1'b0, 2'd0},
    {64'h0000_0001_0000_0000, 1'b0, 1'b1, 2'd3},
    {64'h0000_0001_0FFF_FFFF, 1'b0, 1'b1, 2'd3},
    {64'h0000_0001_1000_0000, 1'b0, 1'b0, 2'd0},
    {64'h0000_0000_0FFF_FFFF, 1'b0, 1'b0, 2'd0},
    {64'h0000_0000_000A_0000, 1'b0, 1'b1, 2'd0},
    {64'h0000_0000_000B_FFFF, 1'b0, 1'b1, 2'd0},
    {64'h0000_0000_000C_0000, 1'b0, 1'b0, 2'd0},
    {64'h0000_0000_0009_FFFF, 1'b0, 1'b0, 2'd0},
    {64'h0000_0000_0001_2000, 1'b0, 1'b0, 2'd0},
    {64'h0000_0000_C010_0000, 1'b1, 1'b0, 2'd0},
    {64'h0000_0000_0000_03C0, 1'b0, 1'b0, 2'd0},
    {64'h0000_0000_000A_0000, 1'b1, 1'b0, 2'd0}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got vld/hit/win=%b expected %b", req, act, exp);
    end
  endtask

  // one request, sampled at the negedge after the capturing posedge
  task automatic send(input logic [63:0] a, input logic io, input string req,
                      input logic eh, input logic [1:0] ew);
    @(negedge clk);
    req_vld = 1'b1; req_addr = a; req_io = io;
    @(posedge clk);
    @(negedge clk);
    req_vld = 1'b0;
    chk(req, {1'b1, hit_vld, hit, win} , {1'b1, 1'b1, eh, ew});
  endtask

  task automatic base_cfg();
    io_base = 8'h21; io_base_hi = 16'h0001;
    io_limit = 8'h31; io_limit_hi = 16'h0001;
    mem_base = 16'hC010; mem_limit = 16'hC030;
    pf_base = 16'h0001; pf_base_hi = 32'h1;
    pf_limit = 16'h0FF1; pf_limit_hi = 32'h1;
    cmd_io = 1'b1; cmd_mem = 1'b1; vga_en = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    req_vld = 0; req_io = 0; req_addr = '0;
    base_cfg();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset", {1'b0, hit_vld, hit, win}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", {1'b0, hit_vld, hit, win}, 4'b0000);

    // table: R2 R3 R4 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][67:4], VEC[i][3], $sformatf("R2/R3/R4/R7/R8 vec %0d", i),
           VEC[i][2], VEC[i][1:0]);
    end

    // R1 latency and hold
    send(64'h1_2000, 1'b1, "R1 strobe", 1'b1, 2'd1);
    req_addr = 64'hC010_0000; req_io = 1'b0;
    @(negedge clk);
    chk("R1 idle hold", {1'b0, hit_vld, hit, win}, {1'b0, 1'b0, 1'b1, 2'd1});

    // R5 enables
    cmd_io = 1'b0;
    send(64'h1_2000, 1'b1, "R5 io disabled", 1'b0, 2'd0);
    send(64'h3C0, 1'b1, "R7 legacy io ignores command enable", 1'b1, 2'd0);
    cmd_io = 1'b1; cmd_mem = 1'b0;
    send(64'hC010_0000, 1'b0, "R5 mem disabled", 1'b0, 2'd0);
    send(64'h1_0000_0000, 1'b0, "R5 pref disabled", 1'b0, 2'd0);
    send(64'hA0000, 1'b0, "R7 legacy mem ignores command enable", 1'b1, 2'd0);
    cmd_mem = 1'b1;

    // R7 legacy gating off
    vga_en = 1'b0;
    send(64'h3B0, 1'b1, "R7 legacy io off", 1'b0, 2'd0);
    send(64'hBFFFF, 1'b0, "R7 legacy mem off", 1'b0, 2'd0);
    vga_en = 1'b1;

    // R6 empty window
    mem_limit = 16'hC000;
    send(64'hC010_0000, 1'b0, "R6 empty at base", 1'b0, 2'd0);
    send(64'hC00F_FFFF, 1'b0, "R6 empty at limit", 1'b0, 2'd0);
    mem_limit = 16'hC030;

    // R2 narrow I/O: upper registers ignored
    io_base = 8'h20; io_limit = 8'h30;
    send(64'h2000, 1'b1, "R2 16-bit io base", 1'b1, 2'd1);
    send(64'h3FFF, 1'b1, "R2 16-bit io limit", 1'b1, 2'd1);
    send(64'h1_2000, 1'b1, "R2 16-bit io ignores upper", 1'b0, 2'd0);
    io_base = 8'h21; io_limit = 8'h31;

    // R4 narrow prefetchable: upper registers ignored
    pf_base = 16'h0010; pf_limit = 16'h0020;
    send(64'h0010_0000, 1'b0, "R4 32-bit pref base", 1'b1, 2'd3);
    send(64'h002F_FFFF, 1'b0, "R4 32-bit pref limit", 1'b1, 2'd3);
    send(64'h1_0010_0000, 1'b0, "R4 32-bit pref ignores upper", 1'b0, 2'd0);

    // R9 priority between overlapping windows
    pf_base = 16'hC000; pf_limit = 16'hC0F0;
    send(64'hC010_0000, 1'b0, "R9 mem over pref", 1'b1, 2'd2);
    send(64'hC000_0000, 1'b0, "R9 pref only", 1'b1, 2'd3);
    mem_base = 16'h0000; mem_limit = 16'h0000;
    send(64'hA0000, 1'b0, "R9 mem over legacy", 1'b1, 2'd2);
    io_base = 8'h00; io_limit = 8'h00;
    send(64'h3B0, 1'b1, "R9 io over legacy", 1'b1, 2'd1);

    // R10 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset asserted", {1'b0, hit_vld, hit, win}, 4'b0000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule